// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block watches the comparator flags of a buck regulator controller and decides when the converter may switch. The flags arrive already synchronised to the clock. They are: a per-pulse overcurrent flag, a short-circuit flag set at twice the overcurrent level, the rising and falling feedback overvoltage flags, a feedback undervoltage flag, and over-temperature rise and hysteresis flags. The block also takes a one-cycle strobe for each PWM pulse, the enable input and a power-on-reset good flag.

From these inputs the block gates the modulator and tells the gate drivers when to ignore it. It chooses the value forced onto the low-side gate, pulls power-good low with a strength code, and keeps one cause bit per fault. Undervoltage, overcurrent, short-circuit and overvoltage latch the converter off. Over-temperature only suspends switching and releases on its own once the temperature falls back through the hysteresis flag. During an overvoltage latch-off, the low-side gate follows the two overvoltage flags so that the output can be clamped. All timers count clock cycles, scaled by a cycles-per-microsecond parameter.

Top module: `fault_supervisor`

## Requirements
- R1: The first PWM strobe that has `oc_over_i` high arms a window of OC_WINDOW_US*CYC_PER_US cycles. If every strobe up to that point also has `oc_over_i` high, the overcurrent cause (`fault_cause_o[0]`) sets on the edge that is exactly that many cycles after the arming edge. Power-good is then pulled with code 2'b01.
- R2: A strobe that has `oc_over_i` low while the window is running disarms it. The next strobe with `oc_over_i` high starts a fresh full window.
- R3: When `sc_over_i` is high for SC_FILTER_US*CYC_PER_US consecutive edges, the short-circuit cause (`fault_cause_o[1]`) sets, with code 2'b01. Any cycle with the flag low restarts the count.
- R4: `ov_rise_i` sets the overvoltage cause (`fault_cause_o[2]`) and drives code 2'b10. Only `por_ok_i` low clears it. Enable low does not.
- R5: While the overvoltage cause is set, `gate_hold_o` is 1 and the high-side gate stays off. `lg_force_o` goes to 1 after `ov_rise_i` and to 0 after `ov_fall_i`, and holds its value in between.
- R6: `uv_i` with enable and power-on-reset good sets the undervoltage cause (`fault_cause_o[3]`) with code 2'b01. This also happens while over-temperature is active. Enable low or `por_ok_i` low clears it.
- R7: `uv_i` has no effect while `en_i` or `por_ok_i` is low.
- R8: `ot_rise_i` sets the over-temperature cause (`fault_cause_o[4]`). This drops `pwm_run_o`, raises `gate_hold_o` with `lg_force_o` at 0, and leaves `pg_pull_o` and `latched_o` unchanged.
- R9: `ot_hys_i`, enable low, or `por_ok_i` low clears the over-temperature cause.
- R10: When overvoltage and any 95-ohm fault are present together, the power-good code is 2'b10.
- R11: After reset all causes are 0 and `pg_pull_o` is 0. `pwm_run_o` is 1 exactly when `en_i` and `por_ok_i` are high and no cause is set, and `gate_hold_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| por_ok_i | input | 1 | Supply above power-on-reset level |
| pwm_pulse_i | input | 1 | One-cycle strobe per PWM pulse |
| oc_over_i | input | 1 | Sense current above threshold on this pulse |
| sc_over_i | input | 1 | Sense current above twice threshold |
| ov_rise_i | input | 1 | Feedback above rising overvoltage level |
| ov_fall_i | input | 1 | Feedback below falling overvoltage level |
| uv_i | input | 1 | Feedback below undervoltage level |
| ot_rise_i | input | 1 | Temperature above rising limit |
| ot_hys_i | input | 1 | Temperature below hysteresis limit |
| pwm_run_o | output | 1 | Modulator allowed to switch |
| gate_hold_o | output | 1 | Drivers take forced values, high side off |
| lg_force_o | output | 1 | Forced low-side gate value |
| pg_pull_o | output | 1 | Power-good pull-down active |
| pg_code_o | output | 2 | Pull strength: 00 none, 01 95 ohm, 10 60 ohm |
| fault_cause_o | output | 5 | {ot, uv, ov, sc, oc} cause bits |
| latched_o | output | 1 | A latching fault is held |

## Verification
Two things can fall in the same cycle. The first is an over-temperature suspension with an undervoltage trip: the bench holds the over-temperature state and then raises undervoltage. It expects both cause bits, the 95-ohm code, and both bits cleared by a single enable-low cycle. The second is an overvoltage latch with an undervoltage latch: the bench sets both and expects the 60-ohm code to win. It then drops enable and checks that the undervoltage bit clears while the overvoltage bit and the low-side clamp remain.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'b00,
    PG_95   = 2'b01,
    PG_60   = 2'b10
  } pg_code_e;

  localparam int unsigned N_CAUSE = 5;
  localparam int unsigned C_OC = 0;
  localparam int unsigned C_SC = 1;
  localparam int unsigned C_OV = 2;
  localparam int unsigned C_UV = 3;
  localparam int unsigned C_OT = 4;
endpackage

// File: rtl/fs_oc_qual.sv
module fs_oc_qual #(
  parameter int unsigned LIM = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pulse_i,
  input  logic over_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIM + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          clean;

  assign clean  = pulse_i && !over_i;
  assign trip_o = armed_q && !clean && (cnt_q == CW'(LIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i || clean || trip_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end else if (pulse_i && over_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end
  end

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pulse_i && !over_i) |=> !armed_q);
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q < CW'(LIM)));
endmodule

// File: rtl/fs_sc_filter.sv
module fs_sc_filter #(
  parameter int unsigned LIM = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sc_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = sc_i && (cnt_q == CW'(LIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i || !sc_i || trip_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  p_drop_resets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_i |=> !trip_o);
endmodule

// File: rtl/fs_fault_regs.sv
module fs_fault_regs
  import fs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               por_ok_i,
  input  logic               oc_trip_i,
  input  logic               sc_trip_i,
  input  logic               ov_rise_i,
  input  logic               ov_fall_i,
  input  logic               uv_i,
  input  logic               ot_rise_i,
  input  logic               ot_hys_i,
  output logic [N_CAUSE-1:0] cause_o,
  output logic               lg_on_o
);
  logic oc_q, sc_q, ov_q, uv_q, ot_q, lg_q;
  logic clr_por, clr_en;

  assign clr_por = !por_ok_i;
  assign clr_en  = !en_i || !por_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= 1'b0; sc_q <= 1'b0; uv_q <= 1'b0; ot_q <= 1'b0;
    end else if (clr_en) begin
      oc_q <= 1'b0; sc_q <= 1'b0; uv_q <= 1'b0; ot_q <= 1'b0;
    end else begin
      if (oc_trip_i) oc_q <= 1'b1;
      if (sc_trip_i) sc_q <= 1'b1;
      if (uv_i)      uv_q <= 1'b1;
      if (ot_rise_i)     ot_q <= 1'b1;
      else if (ot_hys_i) ot_q <= 1'b0;
    end
  end

  // overvoltage survives enable low; low-side clamp tracks hysteresis
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0; lg_q <= 1'b0;
    end else if (clr_por) begin
      ov_q <= 1'b0; lg_q <= 1'b0;
    end else begin
      if (ov_rise_i)      begin ov_q <= 1'b1; lg_q <= 1'b1; end
      else if (ov_fall_i) lg_q <= 1'b0;
    end
  end

  assign cause_o = {ot_q, uv_q, ov_q, sc_q, oc_q};
  assign lg_on_o = lg_q;

  p_ov_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && por_ok_i) |=> ov_q);
  p_uv_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !por_ok_i) |=> !uv_q);
  p_ot_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_hys_i && !ot_rise_i) |=> !ot_q);
  p_lg_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_fall_i && !ov_rise_i) |=> !lg_q);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int unsigned CYC_PER_US    = 125,
  parameter int unsigned OC_WINDOW_US  = 20,
  parameter int unsigned SC_FILTER_US  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       por_ok_i,
  input  logic       pwm_pulse_i,
  input  logic       oc_over_i,
  input  logic       sc_over_i,
  input  logic       ov_rise_i,
  input  logic       ov_fall_i,
  input  logic       uv_i,
  input  logic       ot_rise_i,
  input  logic       ot_hys_i,
  output logic       pwm_run_o,
  output logic       gate_hold_o,
  output logic       lg_force_o,
  output logic       pg_pull_o,
  output logic [1:0] pg_code_o,
  output logic [4:0] fault_cause_o,
  output logic       latched_o
);
  localparam int unsigned OC_LIM = OC_WINDOW_US * CYC_PER_US;
  localparam int unsigned SC_LIM = SC_FILTER_US * CYC_PER_US;

  logic               oc_trip, sc_trip, lg_on, tmr_clr, latched, pull95;
  logic [N_CAUSE-1:0] cause;

  assign tmr_clr = !en_i || !por_ok_i || latched;

  fs_oc_qual #(.LIM(OC_LIM)) i_oc (
    .clk_i, .rst_ni, .clr_i(tmr_clr),
    .pulse_i(pwm_pulse_i), .over_i(oc_over_i), .trip_o(oc_trip)
  );

  fs_sc_filter #(.LIM(SC_LIM)) i_sc (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .sc_i(sc_over_i), .trip_o(sc_trip)
  );

  fs_fault_regs i_regs (
    .clk_i, .rst_ni, .en_i, .por_ok_i,
    .oc_trip_i(oc_trip), .sc_trip_i(sc_trip),
    .ov_rise_i, .ov_fall_i, .uv_i, .ot_rise_i, .ot_hys_i,
    .cause_o(cause), .lg_on_o(lg_on)
  );

  assign pull95  = cause[C_OC] | cause[C_SC] | cause[C_UV];
  assign latched = pull95 | cause[C_OV];

  always_comb begin
    if (cause[C_OV]) pg_code_o = PG_60;
    else if (pull95) pg_code_o = PG_95;
    else             pg_code_o = PG_NONE;
  end

  assign pwm_run_o     = en_i && por_ok_i && !latched && !cause[C_OT];
  assign gate_hold_o   = !pwm_run_o;
  assign lg_force_o    = cause[C_OV] && lg_on;
  assign pg_pull_o     = latched;
  assign fault_cause_o = cause;
  assign latched_o     = latched;

  p_ot_stops_pwm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_cause_o[C_OT] |-> (gate_hold_o && !pwm_run_o));
  p_ov_holds_gates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_cause_o[C_OV] |-> gate_hold_o);
  p_code_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pg_code_o) && (pg_pull_o == (pg_code_o != PG_NONE)));
  p_lg_only_ov_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lg_force_o |-> fault_cause_o[C_OV]);
endmodule

// File: tb/test_fault_supervisor.sv
`timescale 1ns/1ps
module test_fault_supervisor;
  localparam int unsigned CPU    = 125;
  localparam int unsigned OC_LIM = 20 * CPU;
  localparam int unsigned SC_LIM = 2 * CPU;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en, por, pulse, oc, sc, ovr, ovf, uv, otr, oth;
  logic run, hold, lgf, pull, latched;
  logic [1:0] code;
  logic [4:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.CYC_PER_US(CPU), .OC_WINDOW_US(20), .SC_FILTER_US(2)) i_fault_supervisor (
    .clk_i(clk), .rst_ni, .en_i(en), .por_ok_i(por), .pwm_pulse_i(pulse),
    .oc_over_i(oc), .sc_over_i(sc), .ov_rise_i(ovr), .ov_fall_i(ovf),
    .uv_i(uv), .ot_rise_i(otr), .ot_hys_i(oth),
    .pwm_run_o(run), .gate_hold_o(hold), .lg_force_o(lgf), .pg_pull_o(pull),
    .pg_code_o(code), .fault_cause_o(cause), .latched_o(latched)
  );

  // in: {en,por,uv,ovr,ovf,otr,oth}; out: {run,hold,lg,pull}
  typedef struct packed {
    logic [6:0] in;
    logic [3:0] out;
    logic [1:0] code;
    logic [4:0] cause;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{7'b1100000, 4'b1000, 2'd0, 5'b00000, 4'd11}, // R11
    '{7'b0110000, 4'b0100, 2'd0, 5'b00000, 4'd7},  // R7 blanked
    '{7'b1110000, 4'b0101, 2'd1, 5'b01000, 4'd6},  // R6
    '{7'b1100000, 4'b0101, 2'd1, 5'b01000, 4'd6},
    '{7'b0100000, 4'b0100, 2'd0, 5'b00000, 4'd6},
    '{7'b1100000, 4'b1000, 2'd0, 5'b00000, 4'd6},
    '{7'b1100010, 4'b0100, 2'd0, 5'b10000, 4'd8},  // R8
    '{7'b1100000, 4'b0100, 2'd0, 5'b10000, 4'd8},
    '{7'b1100001, 4'b1000, 2'd0, 5'b00000, 4'd9},  // R9 hysteresis
    '{7'b1100010, 4'b0100, 2'd0, 5'b10000, 4'd8},
    '{7'b1110000, 4'b0101, 2'd1, 5'b11000, 4'd6},  // R6 during OT
    '{7'b0100000, 4'b0100, 2'd0, 5'b00000, 4'd9},  // R9 enable low
    '{7'b1101000, 4'b0111, 2'd2, 5'b00100, 4'd4},  // R4
    '{7'b1100000, 4'b0111, 2'd2, 5'b00100, 4'd5},  // R5 hold
    '{7'b1100100, 4'b0101, 2'd2, 5'b00100, 4'd5},
    '{7'b1101000, 4'b0111, 2'd2, 5'b00100, 4'd5},
    '{7'b1110000, 4'b0111, 2'd2, 5'b01100, 4'd10}, // R10
    '{7'b0100000, 4'b0111, 2'd2, 5'b00100, 4'd4},  // R4 enable low keeps OV
    '{7'b1000000, 4'b0100, 2'd0, 5'b00000, 4'd4},  // R4 POR clears
    '{7'b1100000, 4'b1000, 2'd0, 5'b00000, 4'd11},
    '{7'b1100010, 4'b0100, 2'd0, 5'b10000, 4'd8},
    '{7'b1000000, 4'b0100, 2'd0, 5'b00000, 4'd9},  // R9 POR clears OT
    '{7'b1100000, 4'b1000, 2'd0, 5'b00000, 4'd9}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_en();
    en = 1'b0; tick(1); en = 1'b1; tick(1);
  endtask

  // drives ncyc cycles, strobe every 100, oc_over low on cycle clean_at
  task automatic oc_run(int ncyc, int clean_at);
    for (int i = 0; i < ncyc; i++) begin
      pulse = (i % 100 == 0);
      oc    = (i != clean_at);
      @(negedge clk);
    end
    pulse = 1'b0; oc = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    {en, por, pulse, oc, sc, ovr, ovf, uv, otr, oth} = '0;
    en = 1'b1; por = 1'b1;
    tick(3);
    // R11 reset state
    chk("R11 cause", 32'(cause), 0);
    chk("R11 pull", 32'(pull), 0);
    rst_ni = 1'b1;
    tick(1);
    chk("R11 run", 32'(run), 1);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      {en, por, uv, ovr, ovf, otr, oth} = VEC[v].in;
      tick(1);
      chk(tag, 32'({run, hold, lgf, pull}), 32'(VEC[v].out));
      chk(tag, 32'(code), 32'(VEC[v].code));
      chk(tag, 32'(cause), 32'(VEC[v].cause));
    end
    {uv, ovr, ovf, otr, oth} = '0; en = 1'b1; por = 1'b1;
    tick(1);

    // R1 exact window
    oc_run(OC_LIM, -1);
    chk("R1 before window", 32'(cause[0]), 0);
    tick(1);
    chk("R1 at window", 32'(cause[0]), 1);
    chk("R1 code", 32'(code), 1);
    chk("R1 latched", 32'(latched), 1);
    clear_en();
    chk("R1 cleared", 32'(cause), 0);

    // R2 clean pulse at 1000 restarts; rearm at 1100
    oc_run(1100 + OC_LIM, 1000);
    chk("R2 restarted", 32'(cause[0]), 0);
    tick(1);
    chk("R2 after new window", 32'(cause[0]), 1);
    clear_en();

    // R3 drop restarts, then full hold trips
    sc = 1'b1; tick(SC_LIM - 1);
    sc = 1'b0; tick(1);
    chk("R3 drop", 32'(cause[1]), 0);
    sc = 1'b1; tick(SC_LIM - 1);
    chk("R3 short", 32'(cause[1]), 0);
    tick(1);
    chk("R3 trip", 32'(cause[1]), 1);
    chk("R3 code", 32'(code), 1);
    sc = 1'b0;
    clear_en();
    chk("R3 cleared", 32'(cause), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule